// File: doc/BRIEF.md
# Configuration Port Unlock and Parallel-Device Register File

This block is the device side of an index/data configuration interface inside a multi-function I/O controller. Software reaches it through two byte-wide ports: an index port (`bus_sel` = 0) and a data port (`bus_sel` = 1). After reset the interface is locked. To unlock it, software writes a key byte to the index port on two consecutive writes. While it is unlocked, each index write picks a configuration register, and the data port reads or writes the register that was picked. Writing an exit code to the index port locks the interface again.

A logical-device number register decides which device's registers are visible. This block implements only the parallel-port device. Its registers hold an activate bit, a 16-bit I/O base, an interrupt line, a DMA channel and an option byte. The option byte packs the port mode, the FIFO threshold and the interrupt signalling type. The decoded settings drive the block's outputs at all times, whether it is locked or unlocked. Two read-only identification registers report the controller's device and revision codes.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the interface is locked (`cfg_mode_on` = 0). It unlocks on the clock edge of the second of two consecutive writes of KEY (default 0x87) to the index port.
- R2: Any write that comes between the two KEY writes restarts the unlock sequence. This covers a data-port write and an index write of any other value. After such a write, two more consecutive KEY writes are needed.
- R3: While locked, data-port writes change no setting, and `bus_rdata` reads 0xFF on both ports.
- R4: While unlocked, an index-port write stores the register index, and reading the index port returns it. The data port reads and writes the register at that index.
- R5: Writing EXIT (default 0xAA) to the index port while unlocked locks the interface on that edge. All settings keep their values.
- R6: Index 0x07 holds the logical-device number. The device registers (0x30, 0x60, 0x61, 0x70, 0x74, 0xF0) accept writes only when this number equals PAR_LDN (default 1). Otherwise, writes to them are discarded and reads from them return 0xFF.
- R7: Bit 0 of index 0x30 drives `cfg_active`. Index 0x60 is the high byte and index 0x61 the low byte of `cfg_base`. Index 0x30 reads back with bits 7:1 as zero.
- R8: Bits 3:0 of index 0x70 give `cfg_irq`, and the register reads back with its upper nibble as zero. Bits 2:0 of index 0x74 give the DMA code. A code of 0 to 3 sets `cfg_dma_en` = 1 with `cfg_dma_ch` equal to the code. A code above 3 clears `cfg_dma_en`. Index 0x74 reads back with bits 7:3 as zero.
- R9: Index 0xF0 is stored whole and read back whole. Its bits 2:0 drive `cfg_port_mode`, bits 6:3 drive `cfg_fifo_thr`, and bit 7 drives `cfg_irq_follow_ack`.
- R10: Index 0x20 reads DEV_ID (default 0x52) and index 0x21 reads DEV_REV (default 0x7A). Writes to either are discarded.
- R11: Reset values are: base 0x0378, IRQ 7, DMA code 4 (no DMA), option byte 0x00, activate 0, logical device 0.
- R12: Indices with no register read 0x00 while unlocked, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_sel | input | 1 | Port select: 0 = index, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port |
| cfg_mode_on | output | 1 | Configuration interface unlocked |
| cfg_active | output | 1 | Parallel device activated |
| cfg_base | output | 16 | Parallel device I/O base |
| cfg_irq | output | 4 | Interrupt line number |
| cfg_dma_en | output | 1 | DMA channel assigned |
| cfg_dma_ch | output | 2 | DMA channel number |
| cfg_port_mode | output | 3 | Port mode code |
| cfg_fifo_thr | output | 4 | FIFO threshold |
| cfg_irq_follow_ack | output | 1 | 1 = interrupt follows acknowledge, 0 = pulsed |

## Verification
A wrong unlock state shows up on `cfg_mode_on` and `bus_rdata` on the cycle after the write that caused it. A lock that opens early also lets a data write reach a setting output on that same edge. A corrupted index or logical-device number shows up on the very next data-port read, as the wrong register value or as 0xFF. Decode errors show up on the setting outputs one edge after the data write, with no further delay.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    localparam int BYTE_W = 8;
    localparam int BASE_W = 16;
    localparam int IRQ_W  = 4;
    localparam int DMA_W  = 3;

    localparam logic [BYTE_W-1:0] IDX_LDN     = 8'h07;
    localparam logic [BYTE_W-1:0] IDX_ID_HI   = 8'h20;
    localparam logic [BYTE_W-1:0] IDX_ID_LO   = 8'h21;
    localparam logic [BYTE_W-1:0] IDX_ACT     = 8'h30;
    localparam logic [BYTE_W-1:0] IDX_BASE_HI = 8'h60;
    localparam logic [BYTE_W-1:0] IDX_BASE_LO = 8'h61;
    localparam logic [BYTE_W-1:0] IDX_IRQ     = 8'h70;
    localparam logic [BYTE_W-1:0] IDX_DMA     = 8'h74;
    localparam logic [BYTE_W-1:0] IDX_OPT     = 8'hF0;

    typedef enum logic [2:0] {
        PM_SPP_BIDIR   = 3'd0,
        PM_EPP19_SPP   = 3'd1,
        PM_ECP         = 3'd2,
        PM_ECP_EPP19   = 3'd3,
        PM_SPP_ONLY    = 3'd4,
        PM_EPP17_SPP   = 3'd5,
        PM_RESERVED    = 3'd6,
        PM_ECP_EPP17   = 3'd7
    } port_mode_t;

    typedef struct packed {
        logic              act;
        logic [BASE_W-1:0] base;
        logic [IRQ_W-1:0]  irq;
        logic [DMA_W-1:0]  dma;
        logic [BYTE_W-1:0] opt;
    } par_regs_t;
endpackage

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
    import sio_cfg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] KEY  = 8'h87,
    parameter logic [BYTE_W-1:0] EXIT = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic              unlocked
);
    typedef struct packed {
        logic open;
        logic key_seen;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (!st_q.open) begin
                if (!sel && wdata == KEY) begin
                    if (st_q.key_seen) begin
                        st_d.open     = 1'b1;
                        st_d.key_seen = 1'b0;
                    end else begin
                        st_d.key_seen = 1'b1;
                    end
                end else begin
                    st_d.key_seen = 1'b0;
                end
            end else if (!sel && wdata == EXIT) begin
                st_d.open     = 1'b0;
                st_d.key_seen = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unlocked = st_q.open;
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PAR_LDN  = 8'h01,
    parameter logic [BYTE_W-1:0] DEV_ID   = 8'h52,
    parameter logic [BYTE_W-1:0] DEV_REV  = 8'h7A,
    parameter logic [BASE_W-1:0] RST_BASE = 16'h0378,
    parameter logic [IRQ_W-1:0]  RST_IRQ  = 4'd7,
    parameter logic [DMA_W-1:0]  RST_DMA  = 3'd4,
    parameter logic [BYTE_W-1:0] RST_OPT  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlocked,
    input  logic              wr,
    input  logic              sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output par_regs_t         regs
);
    localparam int BPAD = BYTE_W - BASE_W / 2;
    localparam int IPAD = BYTE_W - IRQ_W;
    localparam int DPAD = BYTE_W - DMA_W;
    localparam logic [BYTE_W-1:0] NO_DEV = '1;

    typedef struct packed {
        logic [BYTE_W-1:0] index;
        logic [BYTE_W-1:0] ldn;
        par_regs_t         par;
    } rf_st_t;

    rf_st_t st_d, st_q;
    logic   dev_sel;
    logic   dev_idx;

    assign dev_sel = (st_q.ldn == PAR_LDN);

    always_comb begin
        unique case (st_q.index)
            IDX_ACT, IDX_BASE_HI, IDX_BASE_LO,
            IDX_IRQ, IDX_DMA, IDX_OPT: dev_idx = 1'b1;
            default:                   dev_idx = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (unlocked && wr) begin
            if (!sel) begin
                st_d.index = wdata;
            end else if (st_q.index == IDX_LDN) begin
                st_d.ldn = wdata;
            end else if (dev_sel) begin
                unique case (st_q.index)
                    IDX_ACT:     st_d.par.act = wdata[0];
                    IDX_BASE_HI: st_d.par.base[BASE_W-1:BASE_W/2] = wdata[BASE_W/2-1:0];
                    IDX_BASE_LO: st_d.par.base[BASE_W/2-1:0] = wdata[BASE_W/2-1:0];
                    IDX_IRQ:     st_d.par.irq = wdata[IRQ_W-1:0];
                    IDX_DMA:     st_d.par.dma = wdata[DMA_W-1:0];
                    IDX_OPT:     st_d.par.opt = wdata;
                    default:     st_d = st_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.index    <= '0;
            st_q.ldn      <= '0;
            st_q.par.act  <= 1'b0;
            st_q.par.base <= RST_BASE;
            st_q.par.irq  <= RST_IRQ;
            st_q.par.dma  <= RST_DMA;
            st_q.par.opt  <= RST_OPT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (!unlocked) begin
            rdata = NO_DEV;
        end else if (!sel) begin
            rdata = st_q.index;
        end else if (dev_idx && !dev_sel) begin
            rdata = NO_DEV;
        end else begin
            unique case (st_q.index)
                IDX_LDN:     rdata = st_q.ldn;
                IDX_ID_HI:   rdata = DEV_ID;
                IDX_ID_LO:   rdata = DEV_REV;
                IDX_ACT:     rdata = {{(BYTE_W-1){1'b0}}, st_q.par.act};
                IDX_BASE_HI: rdata = {{BPAD{1'b0}}, st_q.par.base[BASE_W-1:BASE_W/2]};
                IDX_BASE_LO: rdata = {{BPAD{1'b0}}, st_q.par.base[BASE_W/2-1:0]};
                IDX_IRQ:     rdata = {{IPAD{1'b0}}, st_q.par.irq};
                IDX_DMA:     rdata = {{DPAD{1'b0}}, st_q.par.dma};
                IDX_OPT:     rdata = st_q.par.opt;
                default:     rdata = '0;
            endcase
        end
    end

    assign regs = st_q.par;
endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
    import sio_cfg_pkg::*;
(
    input  par_regs_t         regs,
    output logic              active,
    output logic [BASE_W-1:0] base,
    output logic [IRQ_W-1:0]  irq,
    output logic              dma_en,
    output logic [1:0]        dma_ch,
    output logic [2:0]        mode,
    output logic [3:0]        fifo_thr,
    output logic              irq_follow_ack
);
    localparam logic [DMA_W-1:0] DMA_MAX = 3'd3;

    port_mode_t pm;

    always_comb begin
        pm             = port_mode_t'(regs.opt[2:0]);
        active         = regs.act;
        base           = regs.base;
        irq            = regs.irq;
        dma_en         = (regs.dma <= DMA_MAX);
        dma_ch         = regs.dma[1:0];
        mode           = pm;
        fifo_thr       = regs.opt[6:3];
        irq_follow_ack = regs.opt[7];
    end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0]  KEY      = 8'h87,
    parameter logic [7:0]  EXIT     = 8'hAA,
    parameter logic [7:0]  PAR_LDN  = 8'h01,
    parameter logic [7:0]  DEV_ID   = 8'h52,
    parameter logic [7:0]  DEV_REV  = 8'h7A,
    parameter logic [15:0] RST_BASE = 16'h0378,
    parameter logic [3:0]  RST_IRQ  = 4'd7,
    parameter logic [2:0]  RST_DMA  = 3'd4,
    parameter logic [7:0]  RST_OPT  = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_sel,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        cfg_mode_on,
    output logic        cfg_active,
    output logic [15:0] cfg_base,
    output logic [3:0]  cfg_irq,
    output logic        cfg_dma_en,
    output logic [1:0]  cfg_dma_ch,
    output logic [2:0]  cfg_port_mode,
    output logic [3:0]  cfg_fifo_thr,
    output logic        cfg_irq_follow_ack
);
    par_regs_t par;
    logic      unlocked;

    sio_cfg_unlock #(.KEY(KEY), .EXIT(EXIT)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .sel      (bus_sel),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    sio_cfg_regs #(
        .PAR_LDN (PAR_LDN), .DEV_ID (DEV_ID), .DEV_REV (DEV_REV),
        .RST_BASE(RST_BASE), .RST_IRQ(RST_IRQ), .RST_DMA(RST_DMA),
        .RST_OPT (RST_OPT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .unlocked (unlocked),
        .wr       (bus_wr),
        .sel      (bus_sel),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .regs     (par)
    );

    sio_cfg_decode u_decode (
        .regs           (par),
        .active         (cfg_active),
        .base           (cfg_base),
        .irq            (cfg_irq),
        .dma_en         (cfg_dma_en),
        .dma_ch         (cfg_dma_ch),
        .mode           (cfg_port_mode),
        .fifo_thr       (cfg_fifo_thr),
        .irq_follow_ack (cfg_irq_follow_ack)
    );

    assign cfg_mode_on = unlocked;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter logic [7:0] KEY  = 8'h87,
    parameter logic [7:0] EXIT = 8'hAA
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_sel,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        cfg_mode_on,
    input logic        cfg_active,
    input logic [15:0] cfg_base,
    input logic [3:0]  cfg_irq,
    input logic [2:0]  cfg_port_mode
);
    logic key_wr;
    assign key_wr = bus_wr && !bus_sel && (bus_wdata == KEY);

    // R3: locked reads give all ones
    p_locked_reads_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode_on |-> bus_rdata == 8'hFF);

    // R3: nothing written while locked reaches the settings
    p_locked_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode_on |=> ($stable(cfg_base) && $stable(cfg_irq)
                          && $stable(cfg_port_mode) && $stable(cfg_active)));

    // R1: the unlock edge is always caused by a key write
    p_unlock_by_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode_on) |-> $past(key_wr));

    // R2: any non-key cycle while locked keeps the lock
    p_no_unlock_without_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode_on && !key_wr) |=> !cfg_mode_on);

    // R5: the exit code relocks on its edge
    p_exit_relocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_on && bus_wr && !bus_sel && bus_wdata == EXIT) |=> !cfg_mode_on);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.KEY(KEY), .EXIT(EXIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_sel       (bus_sel),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .cfg_mode_on   (cfg_mode_on),
    .cfg_active    (cfg_active),
    .cfg_base      (cfg_base),
    .cfg_irq       (cfg_irq),
    .cfg_port_mode (cfg_port_mode)
);

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;
    localparam logic [7:0] KEY  = 8'h87;
    localparam logic [7:0] EXIT = 8'hAA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        cfg_mode_on, cfg_active, cfg_dma_en, cfg_irq_follow_ack;
    logic [15:0] cfg_base;
    logic [3:0]  cfg_irq, cfg_fifo_thr;
    logic [1:0]  cfg_dma_ch;
    logic [2:0]  cfg_port_mode;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sio_cfg_port u_sio_cfg_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_mode_on(cfg_mode_on),
        .cfg_active(cfg_active), .cfg_base(cfg_base), .cfg_irq(cfg_irq),
        .cfg_dma_en(cfg_dma_en), .cfg_dma_ch(cfg_dma_ch),
        .cfg_port_mode(cfg_port_mode), .cfg_fifo_thr(cfg_fifo_thr),
        .cfg_irq_follow_ack(cfg_irq_follow_ack)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        bus_sel = sel;
        #1 d = bus_rdata;
    endtask

    task automatic unlock();
        wr(1'b0, KEY); wr(1'b0, KEY);
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
        wr(1'b0, idx); wr(1'b1, d);
    endtask

    task automatic get_reg(input logic [7:0] idx, output logic [7:0] d);
        wr(1'b0, idx); rd(1'b1, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 locked after reset", 16'(cfg_mode_on), 16'h0);
        chk("R11 base", cfg_base, 16'h0378);
        chk("R11 irq", 16'(cfg_irq), 16'h7);
        chk("R11 dma none", 16'(cfg_dma_en), 16'h0);
        chk("R11 option", {cfg_irq_follow_ack, cfg_fifo_thr, cfg_port_mode}, 16'h0);
        chk("R11 active", 16'(cfg_active), 16'h0);
        rd(1'b0, v); chk("R3 locked index read", 16'(v), 16'hFF);
    endtask

    task automatic t_broken();
        wr(1'b0, KEY); wr(1'b0, 8'h11); wr(1'b0, KEY);
        chk("R2 index write breaks key", 16'(cfg_mode_on), 16'h0);
        wr(1'b0, 8'h00);
        wr(1'b0, KEY); wr(1'b1, KEY); wr(1'b0, KEY);
        chk("R2 data write breaks key", 16'(cfg_mode_on), 16'h0);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_locked();
        logic [7:0] v;
        wr(1'b1, 8'h55); wr(1'b1, 8'h00);
        chk("R3 locked write no effect base", cfg_base, 16'h0378);
        chk("R3 locked write no effect opt", {cfg_irq_follow_ack, cfg_fifo_thr, cfg_port_mode}, 16'h0);
        rd(1'b1, v); chk("R3 locked data read", 16'(v), 16'hFF);
    endtask

    task automatic t_unlock();
        wr(1'b0, KEY);
        chk("R1 one key stays locked", 16'(cfg_mode_on), 16'h0);
        wr(1'b0, KEY);
        chk("R1 second key unlocks", 16'(cfg_mode_on), 16'h1);
    endtask

    task automatic t_index();
        logic [7:0] v;
        wr(1'b0, 8'h07);
        rd(1'b0, v); chk("R4 index readback", 16'(v), 16'h07);
        rd(1'b1, v); chk("R4 ldn reset value", 16'(v), 16'h00);
        wr(1'b1, 8'h01);
        rd(1'b1, v); chk("R4 data write readback", 16'(v), 16'h01);
    endtask

    task automatic t_fields();
        logic [7:0] v;
        set_reg(8'h30, 8'hFF);
        chk("R7 active", 16'(cfg_active), 16'h1);
        rd(1'b1, v); chk("R7 act readback", 16'(v), 16'h01);
        set_reg(8'h60, 8'h02); set_reg(8'h61, 8'h78);
        chk("R7 base", cfg_base, 16'h0278);
        set_reg(8'h70, 8'hA5);
        chk("R8 irq", 16'(cfg_irq), 16'h5);
        rd(1'b1, v); chk("R8 irq readback", 16'(v), 16'h05);
        set_reg(8'h74, 8'h03);
        chk("R8 dma ch3 en", {cfg_dma_en, cfg_dma_ch}, 16'h7);
        set_reg(8'h74, 8'h05);
        chk("R8 dma 5 none", 16'(cfg_dma_en), 16'h0);
        set_reg(8'h74, 8'h0C);
        chk("R8 dma 4 none", 16'(cfg_dma_en), 16'h0);
        rd(1'b1, v); chk("R8 dma readback", 16'(v), 16'h04);
        set_reg(8'h74, 8'h00);
        chk("R8 dma ch0 en", {cfg_dma_en, cfg_dma_ch}, 16'h4);
        set_reg(8'hF0, 8'hBA);
        chk("R9 mode", 16'(cfg_port_mode), 16'h2);
        chk("R9 threshold", 16'(cfg_fifo_thr), 16'h7);
        chk("R9 irq type", 16'(cfg_irq_follow_ack), 16'h1);
        rd(1'b1, v); chk("R9 opt readback", 16'(v), 16'hBA);
    endtask

    task automatic t_ldn();
        logic [7:0] v;
        set_reg(8'h07, 8'h02);
        set_reg(8'h70, 8'h03);
        chk("R6 other device write discarded", 16'(cfg_irq), 16'h5);
        rd(1'b1, v); chk("R6 other device read", 16'(v), 16'hFF);
        set_reg(8'h07, 8'h01);
        get_reg(8'h70, v); chk("R6 parallel device read", 16'(v), 16'h05);
    endtask

    task automatic t_id();
        logic [7:0] v;
        get_reg(8'h20, v); chk("R10 id", 16'(v), 16'h52);
        wr(1'b1, 8'h00);
        rd(1'b1, v); chk("R10 id write discarded", 16'(v), 16'h52);
        get_reg(8'h21, v); chk("R10 rev", 16'(v), 16'h7A);
    endtask

    task automatic t_unused();
        logic [7:0] v;
        set_reg(8'h45, 8'h33);
        rd(1'b1, v); chk("R12 unused index", 16'(v), 16'h00);
    endtask

    task automatic t_exit();
        logic [7:0] v;
        wr(1'b0, EXIT);
        chk("R5 exit locks", 16'(cfg_mode_on), 16'h0);
        rd(1'b1, v); chk("R5 locked read", 16'(v), 16'hFF);
        chk("R5 base kept", cfg_base, 16'h0278);
        unlock();
        get_reg(8'hF0, v); chk("R5 opt kept after relock", 16'(v), 16'hBA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_broken();
        t_locked();
        t_unlock();
        t_index();
        t_fields();
        t_ldn();
        t_id();
        t_unused();
        t_exit();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule